// File: doc/BRIEF.md
# Reference Clock Frequency Checker

This block tells whether a fast system clock runs at the rate it should. It uses a slow reference clock that is asynchronous to the system clock. The block counts system-clock cycles across one interval of that reference and checks the count against a tolerance window that the user programs. A single-cycle start pulse launches a test. The first qualifying reference edge only locks the test onto the reference. Counting begins at the edge after it.

Two intervals are available, chosen by a mode input that is latched at start:
- **Full period:** from one rising reference edge to the next rising edge.
- **High phase:** the block locks on a falling edge, opens the window at the next rising edge, and closes it at the following falling edge.

With a 32 MHz system clock and a 32768 Hz reference, the nominal counts are about 976 (full) and 488 (high phase). The limits should sit a few counts either side of these values.

The limits and the timeout are latched when a test starts. A missing reference is caught by a per-wait timeout. The verdict appears as a one-cycle done pulse with pass or fail. The measured count stays on the outputs until the next accepted start. The block has no streaming data path, so all of its pins are plain control and status signals with no valid/ready handshake.

Top module: `refclk_rate_checker`

## Requirements
- R1: While reset is asserted, and after it is released, busy_o, done_o, pass_o and fail_o are low and count_o is zero.
- R2: A start_i pulse while busy_o is low starts a test: the next cycle busy_o is high and count_o reads zero.
- R3: With half_mode_i = 0, the first rising reference edge after start is discarded. count_o reports the number of system-clock cycles from that edge to the next rising edge.
- R4: With half_mode_i = 1, the block locks on a falling edge, opens the window at the next rising edge, and reports the number of system-clock cycles from that rising edge to the following falling edge.
- R5: The verdict is pass only when lim_lo_i <= count <= lim_hi_i (both inclusive, values latched at start); otherwise it is fail.
- R6: The count saturates at 2^CNT_W-1 instead of wrapping, and a saturated count is always judged fail.
- R7: If an awaited reference edge has not been seen when timeout_i cycles have passed since the block entered that wait, the test ends with fail. If the edge arrives in the very cycle the timeout would expire, the edge is taken.
- R8: done_o is high for exactly one cycle. In that cycle exactly one of pass_o and fail_o is high and busy_o is low; outside that cycle pass_o and fail_o are low.
- R9: count_o keeps its final value until the next accepted start.
- R10: A start_i pulse while busy_o is high is ignored: the running test continues and its result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock under test |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Slow asynchronous reference clock |
| start_i | input | 1 | Start pulse, honoured only when idle |
| half_mode_i | input | 1 | 0: full period, 1: high phase only |
| lim_lo_i | input | CNT_W | Lowest passing count |
| lim_hi_i | input | CNT_W | Highest passing count |
| timeout_i | input | TMO_W | Longest wait for any single edge, in system clocks (must be at least 1) |
| busy_o | output | 1 | A test is running |
| done_o | output | 1 | One-cycle end-of-test pulse |
| pass_o | output | 1 | Verdict pass, valid with done_o |
| fail_o | output | 1 | Verdict fail, valid with done_o |
| count_o | output | CNT_W | Captured count, held until next start |

## Verification
The closing reference edge and the expiry of the edge timeout can fall on the same system-clock cycle. The bench provokes this by setting timeout_i equal to the reference period in full mode, with the reference edges placed a fixed distance from the clock edges. In that case the edge must win, giving pass with the exact period count. One cycle less of timeout must give fail. A start pulse in the middle of a running test is a second clash; it is judged by checking that the result and the held count match an undisturbed run.

// File: rtl/refchk_pkg.sv
package refchk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOCK = 2'd1,
    ST_ARM  = 2'd2,
    ST_MEAS = 2'd3
  } refchk_state_e;
endpackage

// File: rtl/refchk_edge_det.sv
module refchk_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  // Metastability chain, one flop per stage.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[SYNC_STAGES-1];

  assign rise_o = chain_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/refchk_sat_counter.sv
module refchk_sat_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] plus_o
);
  localparam logic [W-1:0] TOP = '1;

  assign plus_o = (q_o == TOP) ? TOP : q_o + W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= plus_o;
endmodule

// File: rtl/refchk_window_cmp.sv
module refchk_window_cmp #(
  parameter int W = 12
) (
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         inside_o,
  output logic         at_top_o
);
  assign inside_o = (value_i >= lo_i) && (value_i <= hi_i);
  assign at_top_o = &value_i;
endmodule

// File: rtl/refclk_rate_checker.sv
module refclk_rate_checker
  import refchk_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_i,
  input  logic             start_i,
  input  logic             half_mode_i,
  input  logic [CNT_W-1:0] lim_lo_i,
  input  logic [CNT_W-1:0] lim_hi_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [TMO_W-1:0] TMO_ONE = TMO_W'(1);

  refchk_state_e    state_q, state_d;
  logic             half_q;
  logic [CNT_W-1:0] lo_q, hi_q;
  logic [TMO_W-1:0] tmo_q, tmr_q;
  logic             ref_rise, ref_fall;
  logic             start_ok, edge_hit, expired, close_win, finish;
  logic             cnt_clr, cnt_inc, in_win, at_top;
  logic [CNT_W-1:0] cnt_q, cnt_plus, final_cnt;

  refchk_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .async_i(ref_clk_i),
    .rise_o(ref_rise), .fall_o(ref_fall)
  );

  assign start_ok = start_i && (state_q == ST_IDLE);

  // Edge awaited by the current wait.
  always_comb begin
    case (state_q)
      ST_LOCK: edge_hit = half_q ? ref_fall : ref_rise;
      ST_ARM:  edge_hit = ref_rise;
      ST_MEAS: edge_hit = half_q ? ref_fall : ref_rise;
      default: edge_hit = 1'b0;
    endcase
  end

  // An edge in the expiry cycle beats the timeout.
  assign expired   = (state_q != ST_IDLE) && !edge_hit && (tmr_q == tmo_q - TMO_ONE);
  assign close_win = (state_q == ST_MEAS) && edge_hit;
  assign finish    = close_win || expired;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_ok) state_d = ST_LOCK;
      ST_LOCK: if (edge_hit) state_d = half_q ? ST_ARM : ST_MEAS;
      ST_ARM:  if (edge_hit) state_d = ST_MEAS;
      ST_MEAS: if (edge_hit) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (expired) state_d = ST_IDLE;
  end

  assign cnt_clr = start_ok || ((state_d == ST_MEAS) && (state_q != ST_MEAS));
  assign cnt_inc = (state_q == ST_MEAS) && !finish;

  refchk_sat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .q_o(cnt_q), .plus_o(cnt_plus)
  );

  assign final_cnt = close_win ? cnt_plus : cnt_q;

  refchk_window_cmp #(.W(CNT_W)) u_cmp (
    .value_i(final_cnt), .lo_i(lo_q), .hi_i(hi_q),
    .inside_o(in_win), .at_top_o(at_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      half_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      tmo_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= (state_d != state_q) ? '0 : tmr_q + TMO_ONE;
      if (start_ok) begin
        half_q <= half_mode_i;
        lo_q   <= lim_lo_i;
        hi_q   <= lim_hi_i;
        tmo_q  <= timeout_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      pass_o  <= 1'b0;
      fail_o  <= 1'b0;
      count_o <= '0;
    end else begin
      done_o <= finish;
      pass_o <= close_win && in_win && !at_top;
      fail_o <= finish && !(close_win && in_win && !at_top);
      if (start_ok)    count_o <= '0;
      else if (finish) count_o <= final_cnt;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/refchk_props.sv
module refchk_props #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             pass_o,
  input logic             fail_o,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] lo_q,
  input logic [CNT_W-1:0] hi_q
);
  a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && count_o == '0));

  a_r5_pass_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> (count_o >= lo_q && count_o <= hi_q));

  a_r6_saturated_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (&count_o)) |-> fail_o);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((pass_o ^ fail_o) && !busy_o));

  a_r8_quiet_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (!pass_o && !fail_o));

  a_r9_count_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (done_o || $stable(count_o)));

  a_r9_count_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(count_o));
endmodule

bind refclk_rate_checker refchk_props #(.CNT_W(CNT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o), .count_o(count_o),
  .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/sim_refclk_rate_checker.sv
`timescale 1ns/1ps
module sim_refclk_rate_checker;
  localparam int CW  = 12;
  localparam int TW  = 16;
  localparam int TOP = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_clk = 1'b0;
  logic          start = 1'b0;
  logic          half = 1'b0;
  logic [CW-1:0] lim_lo = '0;
  logic [CW-1:0] lim_hi = '0;
  logic [TW-1:0] tmo = '0;
  logic          busy, done, pass, fail;
  logic [CW-1:0] count;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  reported = 0;
  bit  ref_run = 0;
  int  ref_hi = 50;
  int  ref_lo = 50;

  always #5 clk = ~clk;

  refclk_rate_checker #(.CNT_W(CW), .TMO_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .start_i(start),
    .half_mode_i(half), .lim_lo_i(lim_lo), .lim_hi_i(lim_hi),
    .timeout_i(tmo), .busy_o(busy), .done_o(done), .pass_o(pass),
    .fail_o(fail), .count_o(count)
  );

  // Reference edges land 2 ns before each rising clock edge, so counts are exact.
  initial begin
    #3;
    forever begin
      if (ref_run) begin
        ref_clk = 1'b1;
        #(ref_hi * 10);
        ref_clk = 1'b0;
        #(ref_lo * 10);
      end else begin
        ref_clk = 1'b0;
        #10;
      end
    end
  end

  function automatic bit exp_pass(input int c, input int lo, input int hi);
    return (c >= lo) && (c <= hi) && (c != TOP);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    end
  endtask

  task automatic set_ref(input int hi_c, input int lo_c);
    int old;
    old = ref_hi + ref_lo;
    ref_hi = hi_c;
    ref_lo = lo_c;
    ref_run = 1;
    repeat (old + 4) @(negedge clk);
  endtask

  // Runs one test; poke > 0 pulses start again that many cycles in.
  task automatic run(input bit hm, input int llo, input int lhi, input int t,
                     input int poke, output int c, output bit p, output bit f,
                     output int lat);
    @(negedge clk);
    half = hm; lim_lo = CW'(llo); lim_hi = CW'(lhi); tmo = TW'(t);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    chk(busy == 1'b1 && count == '0, "R2 busy and cleared count", int'(count), 0);
    while (!done && lat < 20000) begin
      start = (poke != 0 && lat == poke);
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (poke != 0 && lat == poke + 1)
        chk(busy == 1'b1, "R10 busy kept after extra start", int'(busy), 1);
    end
    c = int'(count); p = pass; f = fail;
    chk(done == 1'b1 && (pass ^ fail) && !busy, "R8 single verdict with done",
        {29'd0, done, pass, fail}, 1);
    @(negedge clk);
    chk(!done && !pass && !fail, "R8 done lasts one cycle", {29'd0, done, pass, fail}, 0);
    repeat (3) @(negedge clk);
    chk(int'(count) == c, "R9 count held", int'(count), c);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int c, lat, e, lo, hi, h, l;
    bit p, f, m;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !fail && count == '0, "R1 reset state", int'(count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !pass && !fail && count == '0, "R1 after release", int'(count), 0);

    // R3 full period nominal
    set_ref(40, 60);
    run(0, 95, 105, 2000, 0, c, p, f, lat);
    chk(c == 100, "R3 full period count", c, 100);
    chk(p && !f, "R5 in window passes", p, 1);

    // R4 high phase only
    set_ref(37, 80);
    run(1, 30, 40, 2000, 0, c, p, f, lat);
    chk(c == 37, "R4 high phase count", c, 37);
    chk(p, "R4 high phase pass", p, 1);

    // R5 boundaries
    set_ref(45, 55);
    run(0, 100, 120, 2000, 0, c, p, f, lat);
    chk(p == 1, "R5 count equals low limit", p, 1);
    run(0, 80, 100, 2000, 0, c, p, f, lat);
    chk(p == 1, "R5 count equals high limit", p, 1);
    run(0, 101, 120, 2000, 0, c, p, f, lat);
    chk(f == 1 && c == 100, "R5 one below low limit fails", f, 1);
    run(0, 80, 99, 2000, 0, c, p, f, lat);
    chk(f == 1 && c == 100, "R5 one above high limit fails", f, 1);

    // R7 edge and timeout in the same cycle
    run(0, 0, 200, 100, 0, c, p, f, lat);
    chk(p == 1 && c == 100, "R7 edge wins at expiry", c, 100);
    run(0, 0, 200, 99, 0, c, p, f, lat);
    chk(f == 1, "R7 timeout one cycle short fails", f, 1);

    // R10 extra start mid-test
    run(0, 90, 110, 2000, 40, c, p, f, lat);
    chk(c == 100 && p, "R10 result unchanged by extra start", c, 100);

    // R6 saturation
    set_ref(2100, 2100);
    run(0, 0, TOP, 10000, 0, c, p, f, lat);
    chk(c == TOP, "R6 saturated count", c, TOP);
    chk(f == 1, "R6 saturated fails", f, 1);

    // R7 missing reference
    ref_run = 0;
    repeat (10) @(negedge clk);
    run(0, 0, TOP, 50, 0, c, p, f, lat);
    chk(f == 1 && c == 0, "R7 dead reference fails", f, 1);
    chk(lat == 51, "R7 timeout latency", lat, 51);
    ref_hi = 0; ref_lo = 0;

    // Random mix, R3 and R4
    for (int i = 0; i < 20; i++) begin
      h = $urandom_range(20, 200);
      l = $urandom_range(20, 200);
      m = $urandom_range(0, 1);
      e = m ? h : h + l;
      lo = e - 15 + $urandom_range(0, 30);
      hi = lo + $urandom_range(0, 30);
      set_ref(h, l);
      run(m, lo, hi, 3000, 0, c, p, f, lat);
      chk(c == e, m ? "R4 random count" : "R3 random count", c, e);
      chk(p == exp_pass(e, lo, hi), "R5 random verdict", p, exp_pass(e, lo, hi));
    end

    report();
    $finish;
  end
endmodule